// File: doc/BRIEF.md
# Four-Plane Priority Compositor with Cursor

This block merges four video planes into one RGB pixel stream. From front to back they are a hardware cursor, two graphics planes (A and B), and a background plane. For every pixel the output takes the colour of the front-most plane that is not transparent. The cursor is always in front and the background is always at the back. The two graphics planes lie between them, and their front/back order can be swapped for each line.

The graphics planes arrive already decoded: a 24-bit colour and an opacity flag per plane per pixel. The bench drives a pixel column counter and a line counter alongside them. The background has two modes. It can show one solid colour. It can also show a rectangular window of an external pixel input, with a second solid colour around that window.

The cursor is a 16x16 single-colour bitmap. Its pattern is loaded one row per register write, and position and colour are loaded with separate writes. All configuration goes into a staging copy. That copy is moved into the working copy on the line-start strobe, so a change never lands part-way through a line. The composed pixel is registered and appears one clock after its inputs.

Top module: `plane_mixer`

## Requirements
- R1: While reset is high, and after it is released until the first staged value is committed, all settings read as zero: cursor off, A in front of B, solid background of colour 0. The output register reads 0.
- R2: When the cursor covers a pixel, the output is the cursor colour, whatever the other planes hold.
- R3: The cursor covers a pixel when all of the following hold: cursor enable is set; x is at least cx and below cx+16; y is at least cy and below cy+16; and bit (15 - (x - cx)) of pattern row (y - cy) is 1. Bit 15 is the leftmost column. Pattern row r is written at address r (0..15) from data[15:0].
- R4: When the cursor does not cover a pixel, the front graphics plane's colour is shown if that plane is opaque. A is the front plane when the B-front bit is 0, and B is the front plane when it is 1.
- R5: When the cursor does not cover a pixel and the front graphics plane is transparent, the back graphics plane's colour is shown if that plane is opaque.
- R6: With both graphics planes transparent and the window mode off, the output is the solid background colour.
- R7: With both graphics planes transparent and the window mode on, the external pixel input is shown when x0 <= x < x1 and y0 <= y < y1. Outside that range the surround colour is shown.
- R8: A register write changes only the staging copy. The staging copy is moved to the working copy at the clock edge where line_start is high. A write made on that same edge is held until the next line start.
- R9: out_rgb at each clock edge is composed from the pixel inputs sampled at that edge and the working copy held before it.
- R10: Register map, with data in cfg_data:
  - 16: cursor position, x in [9:0] and y in [19:10].
  - 17: cursor colour in [23:0].
  - 18: mode. Bit 0 puts B in front, bit 1 selects the window background, bit 2 enables the cursor.
  - 19: solid background colour.
  - 20: surround colour.
  - 21: window x range, x0 in [9:0] and x1 in [19:10].
  - 22: window y range, y0 in [9:0] and y1 in [19:10].
  - Writes to addresses 23 to 31 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | Strobe that commits staged settings |
| pix_x | input | 10 | Current pixel column |
| line_y | input | 10 | Current line |
| a_rgb | input | 24 | Plane A colour (R[23:16], G[15:8], B[7:0]) |
| a_opaque | input | 1 | Plane A pixel is not transparent |
| b_rgb | input | 24 | Plane B colour |
| b_opaque | input | 1 | Plane B pixel is not transparent |
| ext_rgb | input | 24 | External video pixel |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address |
| cfg_data | input | 24 | Register write data |
| out_rgb | output | 24 | Composed pixel, one clock after its inputs |

## Verification
The hardest case to reach is a register write that races a line boundary: the write lands in the same cycle as line_start, or mid-line while the planes are transparent, so the stale working value is the only thing visible. The stimulus forces both planes transparent, writes a new background colour mid-line, and then writes again on the line-start cycle itself. A behavioural model then tracks which value must show on each following pixel. Cursor coverage is reached by sweeping lines across a computed pattern at two positions, one of them at the origin corner. This checks both the bit order and the half-open edges.

// File: rtl/plane_mix_pkg.sv
package plane_mix_pkg;

    localparam int CH_W    = 8;
    localparam int COL_W   = 3 * CH_W;
    localparam int CUR_DEF = 16;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } rgb_t;

    // mode register bit layout: [2] cursor enable, [1] window background, [0] B in front
    typedef struct packed {
        logic cur_en;
        logic win_bg;
        logic b_front;
    } mode_t;

    // control registers follow the cursor pattern rows in the address space
    typedef enum int {
        CTL_POS  = 0,
        CTL_CCOL = 1,
        CTL_MODE = 2,
        CTL_BG   = 3,
        CTL_SUR  = 4,
        CTL_WINX = 5,
        CTL_WINY = 6
    } ctl_reg_e;

    localparam int NUM_CTL = 7;

    // choose between the two graphics planes and the background
    function automatic rgb_t pick_graphics(
        input logic  b_front,
        input logic  a_op,
        input rgb_t  a_pix,
        input logic  b_op,
        input rgb_t  b_pix,
        input rgb_t  bg_pix
    );
        logic front_op;
        logic back_op;
        rgb_t front_pix;
        rgb_t back_pix;
        front_op  = b_front ? b_op  : a_op;
        front_pix = b_front ? b_pix : a_pix;
        back_op   = b_front ? a_op  : b_op;
        back_pix  = b_front ? a_pix : b_pix;
        if (front_op)
            return front_pix;
        else if (back_op)
            return back_pix;
        else
            return bg_pix;
    endfunction

endpackage

// File: rtl/plane_mix_regs.sv
module plane_mix_regs
    import plane_mix_pkg::*;
#(
    parameter int PXW   = 10,
    parameter int LNW   = 10,
    parameter int DW    = 24,
    parameter int CUR_N = CUR_DEF,
    parameter int AW    = 5
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        line_start,
    input  logic                        cfg_we,
    input  logic [AW-1:0]               cfg_addr,
    input  logic [DW-1:0]               cfg_data,
    output logic [CUR_N-1:0][CUR_N-1:0] act_pat,
    output logic [PXW-1:0]              act_cx,
    output logic [LNW-1:0]              act_cy,
    output rgb_t                        act_ccol,
    output mode_t                       act_mode,
    output rgb_t                        act_bg,
    output rgb_t                        act_sur,
    output logic [PXW-1:0]              act_wx0,
    output logic [PXW-1:0]              act_wx1,
    output logic [LNW-1:0]              act_wy0,
    output logic [LNW-1:0]              act_wy1
);

    localparam int CTL_BASE = CUR_N;
    localparam int CTL_LAST = CUR_N + NUM_CTL - 1;

    // pattern rows: one staging and one working register each
    for (genvar r = 0; r < CUR_N; r++) begin : g_row
        logic [CUR_N-1:0] stg_q;
        logic [CUR_N-1:0] act_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                stg_q <= '0;
                act_q <= '0;
            end else begin
                if (line_start)
                    act_q <= stg_q;
                if (cfg_we && cfg_addr == AW'(r))
                    stg_q <= cfg_data[CUR_N-1:0];
            end
        end
        assign act_pat[r] = act_q;
    end

    logic [PXW-1:0] stg_cx;
    logic [LNW-1:0] stg_cy;
    rgb_t           stg_ccol;
    mode_t          stg_mode;
    rgb_t           stg_bg;
    rgb_t           stg_sur;
    logic [PXW-1:0] stg_wx0;
    logic [PXW-1:0] stg_wx1;
    logic [LNW-1:0] stg_wy0;
    logic [LNW-1:0] stg_wy1;

    logic           ctl_hit;
    int             ctl_idx;

    always_comb begin
        ctl_hit = cfg_we && (int'(cfg_addr) >= CTL_BASE) && (int'(cfg_addr) <= CTL_LAST);
        ctl_idx = int'(cfg_addr) - CTL_BASE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_cx   <= '0;
            stg_cy   <= '0;
            stg_ccol <= '0;
            stg_mode <= '0;
            stg_bg   <= '0;
            stg_sur  <= '0;
            stg_wx0  <= '0;
            stg_wx1  <= '0;
            stg_wy0  <= '0;
            stg_wy1  <= '0;
        end else if (ctl_hit) begin
            case (ctl_idx)
                CTL_POS: begin
                    stg_cx <= cfg_data[PXW-1:0];
                    stg_cy <= cfg_data[PXW+LNW-1:PXW];
                end
                CTL_CCOL: stg_ccol <= rgb_t'(cfg_data[COL_W-1:0]);
                CTL_MODE: stg_mode <= mode_t'(cfg_data[2:0]);
                CTL_BG:   stg_bg   <= rgb_t'(cfg_data[COL_W-1:0]);
                CTL_SUR:  stg_sur  <= rgb_t'(cfg_data[COL_W-1:0]);
                CTL_WINX: begin
                    stg_wx0 <= cfg_data[PXW-1:0];
                    stg_wx1 <= cfg_data[2*PXW-1:PXW];
                end
                CTL_WINY: begin
                    stg_wy0 <= cfg_data[LNW-1:0];
                    stg_wy1 <= cfg_data[2*LNW-1:LNW];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_cx   <= '0;
            act_cy   <= '0;
            act_ccol <= '0;
            act_mode <= '0;
            act_bg   <= '0;
            act_sur  <= '0;
            act_wx0  <= '0;
            act_wx1  <= '0;
            act_wy0  <= '0;
            act_wy1  <= '0;
        end else if (line_start) begin
            act_cx   <= stg_cx;
            act_cy   <= stg_cy;
            act_ccol <= stg_ccol;
            act_mode <= stg_mode;
            act_bg   <= stg_bg;
            act_sur  <= stg_sur;
            act_wx0  <= stg_wx0;
            act_wx1  <= stg_wx1;
            act_wy0  <= stg_wy0;
            act_wy1  <= stg_wy1;
        end
    end

endmodule

// File: rtl/plane_mix_cursor.sv
module plane_mix_cursor
    import plane_mix_pkg::*;
#(
    parameter int PXW   = 10,
    parameter int LNW   = 10,
    parameter int CUR_N = CUR_DEF
) (
    input  logic [PXW-1:0]              pix_x,
    input  logic [LNW-1:0]              line_y,
    input  logic                        enable,
    input  logic [PXW-1:0]              cur_x,
    input  logic [LNW-1:0]              cur_y,
    input  logic [CUR_N-1:0][CUR_N-1:0] pattern,
    output logic                        hit
);

    // CUR_N is taken to be a power of two
    localparam int CIW = $clog2(CUR_N);

    logic [PXW-1:0]   dx;
    logic [LNW-1:0]   dy;
    logic             in_x;
    logic             in_y;
    logic [CIW-1:0]   row_i;
    logic [CIW-1:0]   col_i;
    logic [CUR_N-1:0] row_bits;

    always_comb begin
        dx       = pix_x - cur_x;
        dy       = line_y - cur_y;
        in_x     = (pix_x >= cur_x) && (dx < PXW'(CUR_N));
        in_y     = (line_y >= cur_y) && (dy < LNW'(CUR_N));
        row_i    = dy[CIW-1:0];
        col_i    = CIW'(CUR_N - 1) - dx[CIW-1:0];
        row_bits = pattern[row_i];
        hit      = enable && in_x && in_y && row_bits[col_i];
    end

endmodule

// File: rtl/plane_mix_bg.sv
module plane_mix_bg
    import plane_mix_pkg::*;
#(
    parameter int PXW = 10,
    parameter int LNW = 10
) (
    input  logic [PXW-1:0] pix_x,
    input  logic [LNW-1:0] line_y,
    input  logic           win_mode,
    input  rgb_t           solid,
    input  rgb_t           surround,
    input  rgb_t           ext_pix,
    input  logic [PXW-1:0] wx0,
    input  logic [PXW-1:0] wx1,
    input  logic [LNW-1:0] wy0,
    input  logic [LNW-1:0] wy1,
    output rgb_t           bg_pix
);

    logic in_win;

    always_comb begin
        in_win = (pix_x >= wx0) && (pix_x < wx1) && (line_y >= wy0) && (line_y < wy1);
        if (!win_mode)
            bg_pix = solid;
        else if (in_win)
            bg_pix = ext_pix;
        else
            bg_pix = surround;
    end

endmodule

// File: rtl/plane_mixer.sv
module plane_mixer
    import plane_mix_pkg::*;
#(
    parameter int PXW   = 10,
    parameter int LNW   = 10,
    parameter int DW    = 24,
    parameter int CUR_N = CUR_DEF,
    parameter int AW    = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_start,
    input  logic [PXW-1:0]   pix_x,
    input  logic [LNW-1:0]   line_y,
    input  logic [COL_W-1:0] a_rgb,
    input  logic             a_opaque,
    input  logic [COL_W-1:0] b_rgb,
    input  logic             b_opaque,
    input  logic [COL_W-1:0] ext_rgb,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [DW-1:0]    cfg_data,
    output logic [COL_W-1:0] out_rgb
);

    logic [CUR_N-1:0][CUR_N-1:0] act_pat;
    logic [PXW-1:0]              act_cx;
    logic [LNW-1:0]              act_cy;
    rgb_t                        act_ccol;
    mode_t                       act_mode;
    rgb_t                        act_bg;
    rgb_t                        act_sur;
    logic [PXW-1:0]              act_wx0;
    logic [PXW-1:0]              act_wx1;
    logic [LNW-1:0]              act_wy0;
    logic [LNW-1:0]              act_wy1;
    logic                        cur_hit;
    rgb_t                        bg_pix;
    rgb_t                        gfx_pix;
    rgb_t                        mix_pix;
    rgb_t                        out_q;

    plane_mix_regs #(
        .PXW(PXW), .LNW(LNW), .DW(DW), .CUR_N(CUR_N), .AW(AW)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .line_start (line_start),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_data   (cfg_data),
        .act_pat    (act_pat),
        .act_cx     (act_cx),
        .act_cy     (act_cy),
        .act_ccol   (act_ccol),
        .act_mode   (act_mode),
        .act_bg     (act_bg),
        .act_sur    (act_sur),
        .act_wx0    (act_wx0),
        .act_wx1    (act_wx1),
        .act_wy0    (act_wy0),
        .act_wy1    (act_wy1)
    );

    plane_mix_cursor #(
        .PXW(PXW), .LNW(LNW), .CUR_N(CUR_N)
    ) u_cursor (
        .pix_x   (pix_x),
        .line_y  (line_y),
        .enable  (act_mode.cur_en),
        .cur_x   (act_cx),
        .cur_y   (act_cy),
        .pattern (act_pat),
        .hit     (cur_hit)
    );

    plane_mix_bg #(
        .PXW(PXW), .LNW(LNW)
    ) u_bg (
        .pix_x    (pix_x),
        .line_y   (line_y),
        .win_mode (act_mode.win_bg),
        .solid    (act_bg),
        .surround (act_sur),
        .ext_pix  (rgb_t'(ext_rgb)),
        .wx0      (act_wx0),
        .wx1      (act_wx1),
        .wy0      (act_wy0),
        .wy1      (act_wy1),
        .bg_pix   (bg_pix)
    );

    always_comb begin
        gfx_pix = pick_graphics(act_mode.b_front, a_opaque, rgb_t'(a_rgb),
                                b_opaque, rgb_t'(b_rgb), bg_pix);
        mix_pix = cur_hit ? act_ccol : gfx_pix;
    end

    always_ff @(posedge clk) begin
        if (rst)
            out_q <= '0;
        else
            out_q <= mix_pix;
    end

    assign out_rgb = out_q;

endmodule

// File: rtl/plane_mix_chk.sv
module plane_mix_chk
    import plane_mix_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             line_start,
    input logic [COL_W-1:0] a_rgb,
    input logic             a_opaque,
    input logic [COL_W-1:0] b_rgb,
    input logic             b_opaque,
    input logic [COL_W-1:0] out_rgb,
    input logic             cur_hit,
    input rgb_t             act_ccol,
    input mode_t            act_mode,
    input rgb_t             act_bg
);

    p_reset_black_r1: assert property (@(posedge clk)
        rst |=> out_rgb == '0);

    p_cursor_top_r2: assert property (@(posedge clk) disable iff (rst)
        (!rst && cur_hit) |=> out_rgb == $past(act_ccol));

    p_a_front_r4: assert property (@(posedge clk) disable iff (rst)
        (!rst && !cur_hit && !act_mode.b_front && a_opaque) |=> out_rgb == $past(a_rgb));

    p_b_front_r4: assert property (@(posedge clk) disable iff (rst)
        (!rst && !cur_hit && act_mode.b_front && b_opaque) |=> out_rgb == $past(b_rgb));

    p_back_plane_r5: assert property (@(posedge clk) disable iff (rst)
        (!rst && !cur_hit && !act_mode.b_front && !a_opaque && b_opaque) |=> out_rgb == $past(b_rgb));

    p_solid_bg_r6: assert property (@(posedge clk) disable iff (rst)
        (!rst && !cur_hit && !a_opaque && !b_opaque && !act_mode.win_bg) |=> out_rgb == $past(act_bg));

    p_hold_line_r8: assert property (@(posedge clk) disable iff (rst)
        (!rst && !line_start) |=> ($stable(act_mode) && $stable(act_bg) && $stable(act_ccol)));

endmodule

bind plane_mixer plane_mix_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .line_start (line_start),
    .a_rgb      (a_rgb),
    .a_opaque   (a_opaque),
    .b_rgb      (b_rgb),
    .b_opaque   (b_opaque),
    .out_rgb    (out_rgb),
    .cur_hit    (cur_hit),
    .act_ccol   (act_ccol),
    .act_mode   (act_mode),
    .act_bg     (act_bg)
);

// File: tb/sim_plane_mixer.sv
`timescale 1ns/1ps
module sim_plane_mixer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        line_start = 1'b0;
    logic [9:0]  pix_x = '0;
    logic [9:0]  line_y = '0;
    logic [23:0] a_rgb = '0;
    logic        a_opaque = 1'b0;
    logic [23:0] b_rgb = '0;
    logic        b_opaque = 1'b0;
    logic [23:0] ext_rgb = '0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [23:0] cfg_data = '0;
    logic [23:0] out_rgb;

    always #2.5 clk = ~clk;

    plane_mixer u0 (
        .clk(clk), .rst(rst), .line_start(line_start), .pix_x(pix_x), .line_y(line_y),
        .a_rgb(a_rgb), .a_opaque(a_opaque), .b_rgb(b_rgb), .b_opaque(b_opaque),
        .ext_rgb(ext_rgb), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .out_rgb(out_rgb)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string ctx = "";

    // reference model state: staged (s_) and working (w_) copies
    bit [15:0] s_pat [16];
    bit [15:0] w_pat [16];
    int s_cx, s_cy, w_cx, w_cy;
    bit [23:0] s_ccol, w_ccol, s_bg, w_bg, s_sur, w_sur;
    bit [2:0]  s_mode, w_mode;
    int s_wx0, s_wx1, s_wy0, s_wy1, w_wx0, w_wx1, w_wy0, w_wy1;

    bit [23:0] exp_rgb;
    string     exp_tag;
    bit        have_exp = 0;
    int        cur_px = 0;
    int        cur_ln = 0;
    int        op_pct = 50;

    task automatic check(input string tag, input bit [23:0] got, input bit [23:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s [%s] got %06h expected %06h", tag, ctx, got, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 16; i++) begin s_pat[i] = '0; w_pat[i] = '0; end
        s_cx = 0; s_cy = 0; w_cx = 0; w_cy = 0;
        s_ccol = '0; w_ccol = '0; s_bg = '0; w_bg = '0; s_sur = '0; w_sur = '0;
        s_mode = '0; w_mode = '0;
        s_wx0 = 0; s_wx1 = 0; s_wy0 = 0; s_wy1 = 0;
        w_wx0 = 0; w_wx1 = 0; w_wy0 = 0; w_wy1 = 0;
    endtask

    // expected output for the current inputs using the working copy
    task automatic predict();
        int dx, dy;
        bit hit;
        bit fo, bo;
        bit [23:0] fp, bp;
        dx = cur_px - w_cx;
        dy = cur_ln - w_cy;
        hit = w_mode[2] && dx >= 0 && dx < 16 && dy >= 0 && dy < 16 && w_pat[dy][15 - dx];
        fo = w_mode[0] ? b_opaque : a_opaque;
        fp = w_mode[0] ? b_rgb : a_rgb;
        bo = w_mode[0] ? a_opaque : b_opaque;
        bp = w_mode[0] ? a_rgb : b_rgb;
        if (hit) begin exp_rgb = w_ccol; exp_tag = "R2"; end
        else if (fo) begin exp_rgb = fp; exp_tag = "R4"; end
        else if (bo) begin exp_rgb = bp; exp_tag = "R5"; end
        else if (!w_mode[1]) begin exp_rgb = w_bg; exp_tag = "R6"; end
        else if (cur_px >= w_wx0 && cur_px < w_wx1 && cur_ln >= w_wy0 && cur_ln < w_wy1) begin
            exp_rgb = ext_rgb; exp_tag = "R7";
        end else begin exp_rgb = w_sur; exp_tag = "R7"; end
        have_exp = 1;
    endtask

    task automatic model_write(input int addr, input bit [23:0] d);
        if (addr < 16) s_pat[addr] = d[15:0];
        else case (addr)
            16: begin s_cx = d[9:0]; s_cy = d[19:10]; end
            17: s_ccol = d;
            18: s_mode = d[2:0];
            19: s_bg = d;
            20: s_sur = d;
            21: begin s_wx0 = d[9:0]; s_wx1 = d[19:10]; end
            22: begin s_wy0 = d[9:0]; s_wy1 = d[19:10]; end
            default: ; // R10: unused addresses have no effect
        endcase
    endtask

    // one clock: check previous prediction (R9 latency), drive, predict, update model
    task automatic step(input bit ls, input bit we, input int addr, input bit [23:0] d);
        bit [31:0] r1, r2, r3;
        @(negedge clk);
        if (have_exp) check(exp_tag, out_rgb, exp_rgb);
        r1 = $urandom; r2 = $urandom; r3 = $urandom;
        a_rgb = r1[23:0]; b_rgb = r2[23:0]; ext_rgb = r3[23:0];
        a_opaque = ($urandom % 100) < op_pct;
        b_opaque = ($urandom % 100) < op_pct;
        pix_x = cur_px[9:0];
        line_y = cur_ln[9:0];
        line_start = ls;
        cfg_we = we;
        cfg_addr = addr[4:0];
        cfg_data = d;
        predict();
        if (ls) begin
            w_pat = s_pat;
            w_cx = s_cx; w_cy = s_cy; w_ccol = s_ccol; w_mode = s_mode;
            w_bg = s_bg; w_sur = s_sur;
            w_wx0 = s_wx0; w_wx1 = s_wx1; w_wy0 = s_wy0; w_wy1 = s_wy1;
        end
        if (we) model_write(addr, d);
        cur_px++;
    endtask

    task automatic wr(input int addr, input bit [23:0] d);
        step(1'b0, 1'b1, addr, d);
    endtask

    task automatic run_line(input int ln, input int width);
        cur_ln = ln;
        cur_px = 0;
        step(1'b1, 1'b0, 0, '0);
        for (int x = 1; x < width; x++) step(1'b0, 1'b0, 0, '0);
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        ctx = "R1 reset";
        check("R1", out_rgb, 24'h0);

        // R1: defaults: A in front, cursor off, black solid background
        for (int l = 0; l < 3; l++) run_line(l, 32);

        // R4/R5: ordering with A in front then B in front
        ctx = "R4 R5 order";
        wr(18, 24'h000000);
        for (int l = 0; l < 3; l++) run_line(l, 32);
        wr(18, 24'h000001);
        for (int l = 3; l < 7; l++) run_line(l, 32);

        // R6: solid background with mostly transparent planes
        ctx = "R6 solid";
        op_pct = 15;
        wr(19, 24'h3366CC);
        for (int l = 0; l < 3; l++) run_line(l, 32);

        // R8: mid-line write and write on the line-start edge
        ctx = "R8 deferral";
        op_pct = 0;
        cur_ln = 4; cur_px = 0;
        step(1'b1, 1'b0, 0, '0);
        for (int x = 0; x < 5; x++) step(1'b0, 1'b0, 0, '0);
        wr(19, 24'hA1B2C3);
        for (int x = 0; x < 5; x++) step(1'b0, 1'b0, 0, '0);
        cur_px = 0;
        step(1'b1, 1'b1, 19, 24'h0F0F0F);
        for (int x = 0; x < 5; x++) step(1'b0, 1'b0, 0, '0);
        run_line(5, 8);
        @(negedge clk);
        check("R8", out_rgb, 24'h0F0F0F);

        // R7: window background
        ctx = "R7 window";
        op_pct = 10;
        wr(20, 24'h112233);
        wr(21, {4'h0, 10'd15, 10'd5});
        wr(22, {4'h0, 10'd4, 10'd2});
        wr(18, 24'h000002);
        for (int l = 0; l < 7; l++) run_line(l, 24);

        // R10: unused addresses change nothing
        ctx = "R10 unused";
        op_pct = 0;
        wr(18, 24'h000000);
        for (int a = 23; a < 32; a++) wr(a, 24'hFFFFFF);
        for (int l = 0; l < 2; l++) run_line(l, 20);

        // R2/R3: cursor pattern, position and colour
        ctx = "R2 R3 cursor";
        op_pct = 60;
        for (int r = 0; r < 16; r++) wr(r, 24'((r * 16'h1357) ^ 16'h8001));
        wr(16, {4'h0, 10'd3, 10'd8});
        wr(17, 24'hFACE01);
        wr(18, 24'h000005);
        for (int l = 0; l < 22; l++) run_line(l, 30);

        ctx = "R3 corner";
        wr(16, 24'h0);
        wr(18, 24'h000006);
        for (int l = 0; l < 18; l++) run_line(l, 20);

        @(negedge clk);
        if (have_exp) check(exp_tag, out_rgb, exp_rgb);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R9 watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule